// File: doc/BRIEF.md
# One-Hot Vector Address Sequencer

This block takes one vector-address byte and turns it into a series of one-hot select vectors, one vector for each set bit. Each vector picks one byte register of an eight-byte frame data buffer. While a vector is shown, the matching data byte can be written into that register, so only the bytes marked in the input byte are overwritten. Vectors come out starting at the most significant set bit and moving down to the least significant one.

The byte is held in an internal vector register. A mask register is loaded alongside it. Its bits are ones from the top bit down to the highest set bit of the vector register and zeros below that. The select vector comes from the XOR of adjacent mask bits, so no generic priority encoder is needed.

When a vector is accepted, its bit is cleared in the vector register and the mask is recomputed in the same cycle. The block raises `done` once the vector register is empty. At that point the controller around the block may supply the next byte.

Both data paths use valid/ready handshakes:
- The input byte is accepted only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the block is idle, so a byte offered while vectors are still pending waits and has no effect.
- The select output holds its vector for as long as `sel_ready` is low. It advances only on a cycle where `sel_valid` and `sel_ready` are both high.

Top module: `vector_addr_seq`

## Requirements
- R1: After reset, `done`=1, `in_ready`=1, `sel_valid`=0 and `sel_vec`=0.
- R2: The vectors for one byte come out in strictly descending bit order, from the most significant set bit down to the least significant set bit.
- R3: Every vector shown with `sel_valid`=1 has exactly one bit set, and that bit is set in the byte that was loaded. Bit i of `sel_vec` selects buffer byte register i.
- R4: A byte with k set bits yields exactly k accepted vectors, and the XOR of those vectors equals the byte.
- R5: The first vector is valid in the cycle right after the byte is accepted.
- R6: A byte of zero yields no vector: `sel_valid` stays 0, and `done` and `in_ready` stay 1.
- R7: While vectors are pending, `in_ready`=0, and a byte offered with `in_valid`=1 is ignored; the vectors that follow are those of the earlier byte.
- R8: While `sel_valid`=1 and `sel_ready`=0, `sel_vec` stays unchanged and no bit is consumed.
- R9: `done` rises in the cycle after the last vector is accepted, and `in_ready` equals `done` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Vector-address byte offered |
| in_ready | output | 1 | Byte can be accepted (block idle) |
| in_byte | input | 8 | Vector-address byte; bit i marks buffer byte i |
| sel_valid | output | 1 | A select vector is present |
| sel_ready | input | 1 | Consumer takes the select vector this cycle |
| sel_vec | output | 8 | One-hot buffer byte select |
| done | output | 1 | Vector register empty; ready for the next byte |

## Verification
The assertions assume that `in_byte` is meaningful only when `in_valid` is high. They also assume that the consumer may hold `sel_ready` low for any number of cycles, without a limit on the stall. The stimulus changes inputs only on the falling clock edge, so they are stable at every rising edge. The stimulus also presents loads while the block is busy and stalls the output, so that the ignore rule and the hold rule are both exercised alongside the normal walk through each byte's set bits.

// File: rtl/vas_pkg.sv
package vas_pkg;
  localparam int unsigned LANES = 8;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/vas_mask_gen.sv
// Prefix mask: ones from the top lane down to the highest set bit of vbits.
module vas_mask_gen #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vbits,
  output logic [N-1:0] mask
);
  always_comb begin
    mask[N-1] = |vbits;
    for (int j = N - 2; j >= 0; j--) begin
      mask[j] = mask[j+1] & ~vbits[j+1];
    end
  end
endmodule

// File: rtl/vas_onehot_xor.sv
// Turns the prefix mask into a one-hot vector by XOR of adjacent mask bits.
module vas_onehot_xor #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] mask,
  input  logic         vbit0,
  output logic [N-1:0] onehot
);
  assign onehot[0] = mask[0] & vbit0;
  for (genvar j = 0; j < N - 1; j++) begin : g_edge
    assign onehot[j+1] = mask[j] ^ mask[j+1];
  end
endmodule

// File: rtl/vas_regs.sv
// Vector and mask registers with load and clear paths.
module vas_regs #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] load_val,
  input  logic         clr_en,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] vreg,
  output logic [N-1:0] mreg
);
  logic [N-1:0] vnext;
  logic [N-1:0] mnext;

  always_comb begin
    vnext = vreg;
    if (load_en)     vnext = load_val;
    else if (clr_en) vnext = vreg & ~clr_vec;
  end

  vas_mask_gen #(.N(N)) u_mask (.vbits(vnext), .mask(mnext));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg <= '0;
      mreg <= '0;
    end else begin
      vreg <= vnext;
      mreg <= mnext;
    end
  end
endmodule

// File: rtl/vector_addr_seq.sv
module vector_addr_seq
  import vas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       sel_valid,
  input  logic       sel_ready,
  output logic [7:0] sel_vec,
  output logic       done
);
  localparam int unsigned N = LANES;

  lane_vec_t vreg;
  lane_vec_t mreg;
  lane_vec_t onehot;
  logic      accept;
  logic      consume;

  assign done      = ~|vreg;
  assign in_ready  = done;
  assign accept    = in_valid & in_ready;
  assign sel_valid = mreg[N-1];
  assign consume   = sel_valid & sel_ready;
  assign sel_vec   = onehot;

  vas_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_en(accept), .load_val(in_byte),
    .clr_en(consume), .clr_vec(onehot),
    .vreg(vreg), .mreg(mreg)
  );

  vas_onehot_xor #(.N(N)) u_xor (.mask(mreg), .vbit0(vreg[0]), .onehot(onehot));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ($onehot(sel_vec) && ((sel_vec & ~vreg) == '0)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_vec == '0 && done));
  assert_served_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> ((vreg & $past(sel_vec)) == '0));
  assert_descending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (!sel_valid || (sel_vec < $past(sel_vec))));
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !consume) |=> $stable(vreg));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable(sel_vec)));
  assert_zero_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_byte == '0) |=> (done && !sel_valid));
  assert_first_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_byte != '0) |=> sel_valid);
endmodule

// File: tb/vector_addr_seq_tb.sv
module vector_addr_seq_tb;
  localparam int PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [7:0] STIM [NVEC] = '{
    8'h80, 8'h01, 8'hFF, 8'hA5, 8'h5A, 8'h00, 8'h10, 8'hC3, 8'h7E, 8'h24};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic sel_ready = 1'b1;
  logic in_ready, sel_valid, done;
  logic [7:0] sel_vec;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  vector_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .sel_valid(sel_valid), .sel_ready(sel_ready),
    .sel_vec(sel_vec), .done(done));

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] top_bit(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 8'(1) << i;
    return r;
  endfunction

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Walks all vectors of byte b with sel_ready high and checks them.
  task automatic walk(input logic [7:0] b);
    logic [7:0] rem = b;
    logic [7:0] acc = '0;
    int cnt = 0;
    if (b != 0) chk(sel_valid, "R5", {7'b0, sel_valid}, 8'h01);
    for (int guard = 0; guard < 12 && sel_valid; guard++) begin
      chk(sel_vec == top_bit(rem), "R2", sel_vec, top_bit(rem));
      chk($countones(sel_vec) == 1 && (sel_vec & ~b) == 0, "R3", sel_vec, top_bit(rem));
      chk(in_ready == 1'b0, "R7", {7'b0, in_ready}, 8'h00);
      acc ^= sel_vec;
      rem &= ~top_bit(rem);
      cnt++;
      @(negedge clk);
    end
    chk(cnt == $countones(b), "R4", 8'(cnt), 8'($countones(b)));
    chk(acc == b, "R4", acc, b);
    chk(done && in_ready, "R9", {6'b0, done, in_ready}, 8'h03);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    chk(done && in_ready && !sel_valid && sel_vec == 0, "R1",
        sel_vec, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done && in_ready && !sel_valid, "R1", {6'b0, done, sel_valid}, 8'h02);

    for (int k = 0; k < NVEC; k++) begin
      load(STIM[k]);
      if (STIM[k] == 0)
        chk(!sel_valid && done && in_ready, "R6", {7'b0, sel_valid}, 8'h00);
      walk(STIM[k]);
    end

    // R7 and R8: busy load ignored while output is stalled
    load(8'h81);
    sel_ready = 1'b0;
    in_valid  = 1'b1;
    in_byte   = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7", {7'b0, in_ready}, 8'h00);
    chk(sel_valid && sel_vec == 8'h80, "R8", sel_vec, 8'h80);
    in_valid  = 1'b0;
    sel_ready = 1'b1;
    walk(8'h81);

    // R6: zero byte, done never drops
    load(8'h00);
    chk(done && !sel_valid && sel_vec == 0, "R6", sel_vec, 8'h00);

    // R9: done rises right after last vector taken
    load(8'h02);
    chk(!done, "R9", {7'b0, done}, 8'h00);
    @(negedge clk);
    chk(done && in_ready, "R9", {7'b0, done}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule